// File: doc/BRIEF.md
# Fixed-Rate Periodic Interrupt Timer

This block raises a periodic interrupt request for one dedicated task slot (task number 2). A shared prescaler supplies a single-cycle base tick every 0.1 ms. The block counts these ticks up to a period equal to a selected time unit times a 16-bit set value. The unit can be 10 ms, 1 ms or 0.1 ms. When software pulses the restart strobe, the block captures the unit and set value, clears its phase, and starts a new period in that cycle.

The schedule is fixed-rate. The phase counter runs without regard to the acknowledge, so a request that is serviced late does not move later expiries off their time grid. A request stays raised until the dispatcher acknowledges it. If another period expires while a request is still pending, the request stays raised and a sticky overrun flag is set.

A configuration that gives no usable period leaves the timer stopped and raises a configuration error flag. This covers a zero set value, the reserved unit code, and any period below 0.5 ms.

Top module: `sched_irq_timer`

## Requirements
- R1: After reset, irq_req, overrun and cfg_err are 0, and no request is raised until a restart with a valid configuration has been applied.
- R2: The period in base ticks is set_value times the unit multiplier: unit_sel code 0 gives 100 ticks (10 ms), code 1 gives 10 ticks (1 ms), code 2 gives 1 tick (0.1 ms). The first request rises at the clock edge that samples the period's worth of base ticks after the restart. A tick present in the restart cycle is not counted.
- R3: Later requests rise exactly every period's worth of base ticks after the restart, whatever the acknowledge timing.
- R4: irq_req stays 1 until irq_ack is sampled high, and goes to 0 at the following edge. If an ack coincides with a new expiry, irq_req stays 1.
- R5: An expiry while irq_req is 1 and irq_ack is 0 sets overrun. Overrun stays 1 until the next restart or reset. An expiry that coincides with an ack does not set overrun.
- R6: A restart is invalid if set_value is 0, if unit_sel is 3, or if the period is below 5 ticks. An invalid restart sets cfg_err and stops the timer, and no request is raised afterwards. A valid restart clears cfg_err.
- R7: A restart clears the phase, irq_req and overrun, and captures unit_sel and set_value. Later changes to unit_sel or set_value have no effect until the next restart.
- R8: irq_task always reads the configured task number, 2 by default.
- R9: The phase advances only on cycles with base_tick high. Without ticks, no expiry happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | Single-cycle 0.1 ms tick from the prescaler |
| restart | input | 1 | Start/reset strobe; captures configuration and clears phase |
| unit_sel | input | 2 | Time unit code (0: 10 ms, 1: 1 ms, 2: 0.1 ms, 3: reserved) |
| set_value | input | 16 | Period multiplier |
| irq_ack | input | 1 | Acknowledge from the dispatcher |
| irq_req | output | 1 | Pending interrupt request |
| overrun | output | 1 | Sticky flag: a period expired while a request was pending |
| cfg_err | output | 1 | Last restart carried an unusable configuration |
| irq_task | output | 8 | Task number tied to this request |

## Verification
The assertions check the cycle-level rules on every clock: a request is held until it is acknowledged, an ack clears it unless an expiry coincides, overrun is sticky, a restart clears state, the phase stays inside the period and is frozen without ticks, and an error state never raises a request. Some behaviours depend on the tick count over many cycles, and only the bench scenarios can show them. These are the exact period for each unit code, grid alignment under late acknowledges, the rejection of each invalid configuration, and the capture of configuration only at restart. The bench's reference model is compared against the outputs on every cycle.

// File: rtl/sit_pkg.sv
package sit_pkg;
    typedef enum logic [1:0] {
        UNIT_10MS  = 2'd0,
        UNIT_1MS   = 2'd1,
        UNIT_100US = 2'd2,
        UNIT_RSVD  = 2'd3
    } unit_e;

    localparam int unsigned TICKS_10MS  = 100;
    localparam int unsigned TICKS_1MS   = 10;
    localparam int unsigned TICKS_100US = 1;
    localparam int unsigned MIN_TICKS   = 5;
endpackage

// File: rtl/sit_period_calc.sv
module sit_period_calc
    import sit_pkg::*;
#(
    parameter int SV_W = 16,
    parameter int PW   = SV_W + 7
) (
    input  logic [1:0]      unit_sel,
    input  logic [SV_W-1:0] set_value,
    output logic [PW-1:0]   period,
    output logic            valid
);
    logic [PW-1:0] mult;

    always_comb begin
        unique case (unit_e'(unit_sel))
            UNIT_10MS:  mult = PW'(TICKS_10MS);
            UNIT_1MS:   mult = PW'(TICKS_1MS);
            UNIT_100US: mult = PW'(TICKS_100US);
            default:    mult = '0;
        endcase
        period = PW'(set_value) * mult;
        // R6: zero product or product under the floor is unusable
        valid  = (mult != '0) && (period >= PW'(MIN_TICKS));
    end
endmodule

// File: rtl/sit_phase_counter.sv
module sit_phase_counter #(
    parameter int PW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          cfg_valid,
    input  logic [PW-1:0] period_in,
    input  logic          tick,
    output logic          expire,
    output logic          cfg_err
);
    typedef struct packed {
        logic          en;
        logic          err;
        logic [PW-1:0] period;
        logic [PW-1:0] cnt;
    } phase_t;

    phase_t ph_d, ph_q;
    logic   at_end;

    always_comb begin
        ph_d   = ph_q;
        at_end = (ph_q.cnt == ph_q.period - 1'b1);
        expire = 1'b0;
        if (restart) begin
            ph_d.en     = cfg_valid;
            ph_d.err    = ~cfg_valid;
            ph_d.period = period_in;
            ph_d.cnt    = '0;
        end else if (ph_q.en && tick) begin
            expire   = at_end;
            ph_d.cnt = at_end ? '0 : ph_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign cfg_err = ph_q.err;

    a_r2_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.en |-> (ph_q.cnt < ph_q.period));

    a_r9_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(ph_q.cnt));

    a_r6_error_stops_timer: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.err |-> !ph_q.en);
endmodule

// File: rtl/sit_req_ctrl.sv
module sit_req_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic expire,
    input  logic ack,
    output logic req,
    output logic overrun
);
    typedef struct packed {
        logic req;
        logic ovr;
    } rq_t;

    rq_t rq_d, rq_q;

    always_comb begin
        rq_d = rq_q;
        if (restart) begin
            rq_d = '0;
        end else if (expire) begin
            rq_d.req = 1'b1;
            if (rq_q.req && !ack) rq_d.ovr = 1'b1;
        end else if (ack) begin
            rq_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    assign req     = rq_q.req;
    assign overrun = rq_q.ovr;

    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !restart) |=> req);

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !expire && !restart) |=> !req);

    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !restart) |=> overrun);

    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!req && !overrun));
endmodule

// File: rtl/sched_irq_timer.sv
module sched_irq_timer #(
    parameter int SV_W    = 16,
    parameter int TASK_W  = 8,
    parameter int TASK_ID = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              restart,
    input  logic [1:0]        unit_sel,
    input  logic [SV_W-1:0]   set_value,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic              overrun,
    output logic              cfg_err,
    output logic [TASK_W-1:0] irq_task
);
    localparam int PW = SV_W + 7;

    logic [PW-1:0] period;
    logic          cfg_valid;
    logic          expire;

    sit_period_calc #(.SV_W(SV_W), .PW(PW)) u_calc (
        .unit_sel  (unit_sel),
        .set_value (set_value),
        .period    (period),
        .valid     (cfg_valid)
    );

    sit_phase_counter #(.PW(PW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .cfg_valid (cfg_valid),
        .period_in (period),
        .tick      (base_tick),
        .expire    (expire),
        .cfg_err   (cfg_err)
    );

    sit_req_ctrl u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expire  (expire),
        .ack     (irq_ack),
        .req     (irq_req),
        .overrun (overrun)
    );

    assign irq_task = TASK_W'(TASK_ID);

    a_r6_no_request_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!irq_req && !expire));
endmodule

// File: tb/test_sched_irq_timer.sv
`timescale 1ns/1ps
module test_sched_irq_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b0;
    logic        restart = 1'b0;
    logic [1:0]  unit_sel = 2'd0;
    logic [15:0] set_value = 16'd0;
    logic        irq_ack = 1'b0;
    logic        irq_req, overrun, cfg_err;
    logic [7:0]  irq_task;

    always #2 clk = ~clk;

    sched_irq_timer i_sched_irq_timer (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .restart(restart),
        .unit_sel(unit_sel), .set_value(set_value), .irq_ack(irq_ack),
        .irq_req(irq_req), .overrun(overrun), .cfg_err(cfg_err), .irq_task(irq_task)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    int tdiv = 3;
    int tcnt = 0;
    bit tick_on = 0;
    int tick_seen = 0;

    // behavioural reference model
    int m_en, m_err, m_p, m_cnt, m_req, m_ovr;

    always @(negedge clk) begin
        if (tick_on) begin
            base_tick <= (tcnt == tdiv - 1);
            tcnt      <= (tcnt >= tdiv - 1) ? 0 : tcnt + 1;
        end else begin
            base_tick <= 1'b0;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_err = 0; m_p = 0; m_cnt = 0; m_req = 0; m_ovr = 0;
            tick_seen = 0;
        end else if (restart) begin
            int mult;
            mult = (unit_sel == 0) ? 100 : (unit_sel == 1) ? 10 : (unit_sel == 2) ? 1 : 0;
            m_p = mult * int'(set_value);
            if (mult == 0 || m_p < 5) begin m_en = 0; m_err = 1; end
            else begin m_en = 1; m_err = 0; end
            m_cnt = 0; m_req = 0; m_ovr = 0;
            tick_seen = 0;
        end else begin
            bit fire;
            fire = m_en && base_tick && (m_cnt == m_p - 1);
            if (base_tick) tick_seen++;
            if (m_en && base_tick) m_cnt = fire ? 0 : m_cnt + 1;
            if (fire) begin
                if (m_req && !irq_ack) m_ovr = 1;
                m_req = 1;
            end else if (irq_ack) begin
                m_req = 0;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R4 irq_req vs model", int'(irq_req), m_req);
            chk("R5 overrun vs model", int'(overrun), m_ovr);
            chk("R6 cfg_err vs model", int'(cfg_err), m_err);
        end
    end

    task automatic do_restart(int u, int sv);
        @(negedge clk);
        unit_sel = 2'(u); set_value = 16'(sv); restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic wait_req(string tag);
        int n = 0;
        while (!irq_req && n < 3000) begin @(negedge clk); n++; end
        chk({tag, " request seen"}, int'(irq_req), 1);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state, R8 task number
        chk("R1 req at reset", int'(irq_req), 0);
        chk("R1 overrun at reset", int'(overrun), 0);
        chk("R1 cfg_err at reset", int'(cfg_err), 0);
        chk("R8 task number", int'(irq_task), 2);
        rst_n = 1'b1;
        cmp_on = 1;
        tick_on = 1;
        // R1/R9: no request before any restart
        repeat (60) @(negedge clk);
        chk("R1 idle before restart", int'(irq_req), 0);

        // R2: 0.1 ms unit, 5 ticks
        do_restart(2, 5);
        wait_req("R2");
        chk("R2 first request after 5 ticks", tick_seen, 5);
        ack_pulse();
        chk("R4 ack clears request", int'(irq_req), 0);

        // R3: grid kept with late acknowledges (1 ms unit, 10 ticks)
        do_restart(1, 1);
        for (int k = 1; k <= 4; k++) begin
            wait_req("R3");
            chk("R3 request on grid", tick_seen, 10 * k);
            repeat (7 * tdiv) @(negedge clk);
            ack_pulse();
        end

        // R9: ticks stopped, no expiry
        tick_on = 0;
        repeat (80) @(negedge clk);
        chk("R9 no request without ticks", int'(irq_req), 0);
        tick_on = 1;

        // R5: overrun with no acknowledge
        tdiv = 1;
        repeat (3) @(negedge clk);
        do_restart(2, 5);
        wait_req("R5");
        repeat (5) @(negedge clk);
        chk("R5 overrun set", int'(overrun), 1);
        chk("R5 request still up", int'(irq_req), 1);
        ack_pulse();
        chk("R5 overrun sticky after ack", int'(overrun), 1);
        do_restart(2, 5);
        chk("R7 restart clears overrun", int'(overrun), 0);

        // R4: ack coinciding with an expiry
        wait_req("R4");
        while (m_cnt != m_p - 1) @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R4 coincident ack keeps request", int'(irq_req), 1);
        chk("R5 coincident ack no overrun", int'(overrun), 0);
        ack_pulse();

        // R2: 10 ms unit, 100 ticks
        do_restart(0, 1);
        wait_req("R2");
        chk("R2 10 ms unit period", tick_seen, 100);
        ack_pulse();

        // R6: invalid configurations
        do_restart(2, 0);
        chk("R6 zero set value", int'(cfg_err), 1);
        repeat (30) @(negedge clk);
        chk("R6 no request on zero", int'(irq_req), 0);
        do_restart(3, 7);
        chk("R6 reserved unit", int'(cfg_err), 1);
        do_restart(2, 4);
        chk("R6 below floor", int'(cfg_err), 1);
        repeat (30) @(negedge clk);
        chk("R6 no request below floor", int'(irq_req), 0);
        do_restart(2, 5);
        chk("R6 valid restart clears error", int'(cfg_err), 0);

        // R7: configuration captured only at restart
        set_value = 16'd50; unit_sel = 2'd0;
        wait_req("R7");
        chk("R7 later config ignored", tick_seen, 5);
        ack_pulse();

        // R7: restart mid-period clears the phase
        do_restart(1, 1);
        repeat (6) @(negedge clk);
        do_restart(1, 1);
        wait_req("R7");
        chk("R7 phase restarted", tick_seen, 10);
        ack_pulse();

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule